// File: doc/BRIEF.md
# Frame-aware transmit underrun monitor

This block watches the sample FIFOs of a set of transmit channels while packets are drained toward the converter path. Each packet header carries a start-of-frame bit and an end-of-frame bit together with the packet's sample count. For each channel the block keeps a flag that says whether a frame is still open. An empty FIFO becomes an underrun error only while that flag is set. An empty FIFO in the gap between frames is normal and is not reported.

The block also guards the write side of each FIFO. A write aimed at a full FIFO is blocked and recorded as an overrun. A start-of-frame header that arrives while a frame is still open is recorded as a protocol error, and the new header starts a fresh frame. All error flags hold until the host clears them for that channel. Two summary outputs OR the underrun flags and the overrun flags across all channels.

Top module: `frame_urun_mon`

## Requirements
- R1: After a synchronous active-low reset, `in_frame`, `urun_flag`, `ovr_flag`, `proto_err`, `any_urun` and `any_ovr` are all 0. A channel with `in_frame` at 0 is allowed to run dry.
- R2: When `pkt_start` is sampled high with `hdr_sof` high, that channel's `in_frame` is 1 from the next cycle. It stays 1 across any number of following packet starts that have `hdr_sof` low. A packet start with `hdr_sof` low on a channel that is not in a frame leaves `in_frame` at 0.
- R3: An accepted read is `rd_req` high with `fifo_empty` low while samples of the current packet remain. Each accepted read consumes one of the `pkt_len` samples. In the cycle after the accepted read that consumes the last sample of a packet whose header had `hdr_eof` set, `in_frame` returns to 0.
- R4: A packet with both `hdr_sof` and `hdr_eof` set opens the frame and closes it after its own samples. A packet start with `hdr_eof` set and `pkt_len` equal to 0 sets `in_frame` to 0 in the next cycle.
- R5: `rd_req` high with `fifo_empty` high while `in_frame` is 1 sets `urun_flag` for that channel in the next cycle. The same stimulus while `in_frame` is 0 leaves `urun_flag` unchanged.
- R6: A read request made while the FIFO is empty consumes no sample. The frame therefore stays open until enough non-empty reads have been made.
- R7: `wr_pass` equals `wr_req` AND NOT `fifo_full`, in the same cycle. `wr_req` high with `fifo_full` high sets `ovr_flag` in the next cycle.
- R8: A packet start with `hdr_sof` high while `in_frame` is 1 sets `proto_err` in the next cycle. It keeps `in_frame` at 1 and reloads the sample count from the new header.
- R9: `urun_flag`, `ovr_flag` and `proto_err` stay set until `flag_clr` for that channel is high. A clear with no event in the same cycle drops them to 0 in the next cycle. A new event in the same cycle as the clear leaves its flag set.
- R10: Each channel's state depends only on that channel's inputs. `any_urun` is the OR of all `urun_flag` bits and `any_ovr` is the OR of all `ovr_flag` bits. Channel c uses bit c of each vector and bits c*LEN_W and up of `pkt_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pkt_start | input | NUM_CH | Strobe: a packet header is valid on this channel |
| hdr_sof | input | NUM_CH | Start-of-frame bit of the header |
| hdr_eof | input | NUM_CH | End-of-frame bit of the header |
| pkt_len | input | NUM_CH*LEN_W | Sample count of the packet, per channel |
| rd_req | input | NUM_CH | Converter path requests a sample |
| fifo_empty | input | NUM_CH | Channel FIFO holds no sample |
| wr_req | input | NUM_CH | Write request toward the channel FIFO |
| fifo_full | input | NUM_CH | Channel FIFO has no free entry |
| flag_clr | input | NUM_CH | Host clear of the channel's sticky flags |
| wr_pass | output | NUM_CH | Write enable forwarded to the FIFO |
| in_frame | output | NUM_CH | A frame is open on the channel |
| urun_flag | output | NUM_CH | Sticky underrun error |
| ovr_flag | output | NUM_CH | Sticky overrun error |
| proto_err | output | NUM_CH | Sticky start-inside-frame error |
| any_urun | output | 1 | OR of all underrun flags |
| any_ovr | output | 1 | OR of all overrun flags |

## Verification
`in_frame` and the three sticky flags come from registers. They reflect a stimulus one cycle after the clock edge that samples it. `wr_pass` and the write-side decision are combinational and are due in the same cycle. The driver applies each stimulus on a falling edge and then waits for the rising edge. After that edge it queues the expected register values, and the monitor compares them on the next falling edge. `wr_pass` is checked shortly after the driving falling edge, before any rising edge can intervene.

// File: rtl/fum_pkg.sv
// Package: shared definitions for the frame-aware underrun monitor.
// Assumes: flag positions are used only inside this block.
package fum_pkg;
    // Position of each sticky error within a channel's flag bank
    localparam int unsigned FLG_URUN  = 0;
    localparam int unsigned FLG_OVR   = 1;
    localparam int unsigned FLG_PERR  = 2;
    localparam int unsigned NUM_FLAGS = 3;
endpackage

// File: rtl/fum_frame_tracker.sv
// Module: fum_frame_tracker
// Tracks one channel's frame state. The start-of-frame and end-of-frame header
// bits open and close the frame. The packet's sample count is decremented on
// every accepted read. Produces the underrun and protocol-error events for the
// flag bank.
// Assumes: pkt_start marks a header before any of its samples are read. A read
// in the same cycle as pkt_start is not counted against either packet.
module fum_frame_tracker #(
    parameter int unsigned LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_start,
    input  logic             hdr_sof,
    input  logic             hdr_eof,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             rd_req,
    input  logic             fifo_empty,
    output logic             in_frame,
    output logic             urun_evt,
    output logic             perr_evt
);
    localparam logic [LEN_W-1:0] LEN_ZERO = '0;
    localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);

    logic [LEN_W-1:0] remain_q;
    logic             last_eof_q;
    logic             frame_q;
    logic             rd_take;

    // Purpose: a read that actually removes a sample of the current packet
    always_comb rd_take = rd_req && !fifo_empty && (remain_q != LEN_ZERO);

    // Purpose: load the header, count samples and open or close the frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q   <= LEN_ZERO;
            last_eof_q <= 1'b0;
            frame_q    <= 1'b0;
        end else if (pkt_start) begin
            remain_q   <= pkt_len;
            last_eof_q <= hdr_eof;
            if (hdr_eof && (pkt_len == LEN_ZERO)) begin
                frame_q <= 1'b0;
            end else if (hdr_sof) begin
                frame_q <= 1'b1;
            end
        end else if (rd_take) begin
            remain_q <= remain_q - LEN_ONE;
            if ((remain_q == LEN_ONE) && last_eof_q) begin
                frame_q <= 1'b0;
            end
        end
    end

    // Purpose: raise error events from the current frame state
    always_comb begin
        urun_evt = rd_req && fifo_empty && frame_q;
        perr_evt = pkt_start && hdr_sof && frame_q;
    end

    assign in_frame = frame_q;

    // R2
    frame_open_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_q) |-> $past(pkt_start && hdr_sof));

    // R3
    frame_close_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_q) |-> ($past(pkt_start && hdr_eof) || $past(rd_req && !fifo_empty)));

    // R6
    empty_read_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_start && fifo_empty) |=> $stable(remain_q));
endmodule

// File: rtl/fum_sticky_bank.sv
// Module: fum_sticky_bank
// Holds a set of sticky error flags for one channel. An event sets its flag.
// The channel clear drops all flags, but an event in the same cycle as the
// clear wins.
// Assumes: events are single-cycle or level pulses in the clk domain.
module fum_sticky_bank #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr,
    output logic [W-1:0] flags
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic flag_q;

        // Purpose: set on event, hold until clear, event beats clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (evt[b]) begin
                flag_q <= 1'b1;
            end else if (clr) begin
                flag_q <= 1'b0;
            end
        end

        assign flags[b] = flag_q;

        // R9
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt[b] |=> flags[b]);

        // R9
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[b] && !clr) |=> flags[b]);

        // R9
        flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !evt[b]) |=> !flags[b]);
    end
endmodule

// File: rtl/fum_or_reduce.sv
// Module: fum_or_reduce
// ORs a per-channel vector into one summary bit.
// Assumes: the input is already registered, so the output is glitch-free.
module fum_or_reduce #(
    parameter int unsigned N = 2
) (
    input  logic [N-1:0] vec,
    output logic         any
);
    // Purpose: combine all channel bits
    always_comb any = |vec;
endmodule

// File: rtl/frame_urun_mon.sv
// Module: frame_urun_mon
// Monitors NUM_CH transmit channels. Each channel has a frame tracker, a write
// guard that blocks writes into a full FIFO, and a bank of sticky flags for
// underrun, overrun and protocol errors. The underrun and overrun flags are
// also ORed across all channels.
// Assumes: all inputs are synchronous to clk. pkt_len is packed, LEN_W bits
// per channel, with channel 0 in the low bits.
module frame_urun_mon #(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned LEN_W  = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       pkt_start,
    input  logic [NUM_CH-1:0]       hdr_sof,
    input  logic [NUM_CH-1:0]       hdr_eof,
    input  logic [NUM_CH*LEN_W-1:0] pkt_len,
    input  logic [NUM_CH-1:0]       rd_req,
    input  logic [NUM_CH-1:0]       fifo_empty,
    input  logic [NUM_CH-1:0]       wr_req,
    input  logic [NUM_CH-1:0]       fifo_full,
    input  logic [NUM_CH-1:0]       flag_clr,
    output logic [NUM_CH-1:0]       wr_pass,
    output logic [NUM_CH-1:0]       in_frame,
    output logic [NUM_CH-1:0]       urun_flag,
    output logic [NUM_CH-1:0]       ovr_flag,
    output logic [NUM_CH-1:0]       proto_err,
    output logic                    any_urun,
    output logic                    any_ovr
);
    import fum_pkg::*;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic                 urun_evt;
        logic                 perr_evt;
        logic                 ovr_evt;
        logic [NUM_FLAGS-1:0] evt_vec;
        logic [NUM_FLAGS-1:0] flag_vec;

        fum_frame_tracker #(.LEN_W(LEN_W)) i_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .pkt_start (pkt_start[c]),
            .hdr_sof   (hdr_sof[c]),
            .hdr_eof   (hdr_eof[c]),
            .pkt_len   (pkt_len[c*LEN_W +: LEN_W]),
            .rd_req    (rd_req[c]),
            .fifo_empty(fifo_empty[c]),
            .in_frame  (in_frame[c]),
            .urun_evt  (urun_evt),
            .perr_evt  (perr_evt)
        );

        // Purpose: pass writes only when the FIFO has room; flag the rest
        always_comb begin
            wr_pass[c] = wr_req[c] && !fifo_full[c];
            ovr_evt    = wr_req[c] && fifo_full[c];
        end

        // Purpose: gather this channel's events in flag-bank order
        always_comb begin
            evt_vec           = '0;
            evt_vec[FLG_URUN] = urun_evt;
            evt_vec[FLG_OVR]  = ovr_evt;
            evt_vec[FLG_PERR] = perr_evt;
        end

        fum_sticky_bank #(.W(NUM_FLAGS)) i_flags (
            .clk  (clk),
            .rst_n(rst_n),
            .evt  (evt_vec),
            .clr  (flag_clr[c]),
            .flags(flag_vec)
        );

        assign urun_flag[c] = flag_vec[FLG_URUN];
        assign ovr_flag[c]  = flag_vec[FLG_OVR];
        assign proto_err[c] = flag_vec[FLG_PERR];

        // R5
        urun_only_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(urun_flag[c]) |-> $past(in_frame[c] && fifo_empty[c]));

        // R8
        perr_keeps_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pkt_start[c] && hdr_sof[c] && in_frame[c] && !hdr_eof[c]) |=> (proto_err[c] && in_frame[c]));

        // R7
        ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovr_flag[c]) |-> $past(wr_req[c] && fifo_full[c] && !wr_pass[c]));
    end

    fum_or_reduce #(.N(NUM_CH)) i_any_urun (
        .vec(urun_flag),
        .any(any_urun)
    );

    fum_or_reduce #(.N(NUM_CH)) i_any_ovr (
        .vec(ovr_flag),
        .any(any_ovr)
    );
endmodule

// File: tb/test_frame_urun_mon.sv
// Scoreboard bench: the driver applies a stimulus and queues the expected
// registered state; the monitor pops and compares on the following falling edge.
module test_frame_urun_mon;
    localparam int NCH = 2;
    localparam int LW  = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    pkt_start = '0, hdr_sof = '0, hdr_eof = '0;
    logic [NCH*LW-1:0] pkt_len = '0;
    logic [NCH-1:0]    rd_req = '0, fifo_empty = '1, wr_req = '0, fifo_full = '0, flag_clr = '0;
    logic [NCH-1:0]    wr_pass, in_frame, urun_flag, ovr_flag, proto_err;
    logic              any_urun, any_ovr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        string tag;
        int    ch;
        logic  f, u, o, p, au, ao;
    } exp_t;

    exp_t exp_q[$];
    logic e_u[NCH];
    logic e_o[NCH];

    always #10 clk = ~clk;

    frame_urun_mon #(.NUM_CH(NCH), .LEN_W(LW)) i_frame_urun_mon (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .hdr_sof(hdr_sof),
        .hdr_eof(hdr_eof), .pkt_len(pkt_len), .rd_req(rd_req), .fifo_empty(fifo_empty),
        .wr_req(wr_req), .fifo_full(fifo_full), .flag_clr(flag_clr), .wr_pass(wr_pass),
        .in_frame(in_frame), .urun_flag(urun_flag), .ovr_flag(ovr_flag),
        .proto_err(proto_err), .any_urun(any_urun), .any_ovr(any_ovr)
    );

    // Queue the registered state expected after the latest rising edge
    task automatic expect_ch(string tag, int ch, logic f, logic u, logic o, logic p);
        exp_t it;
        e_u[ch] = u;
        e_o[ch] = o;
        it.tag = tag; it.ch = ch; it.f = f; it.u = u; it.o = o; it.p = p;
        it.au = 1'b0; it.ao = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            it.au = it.au | e_u[k];
            it.ao = it.ao | e_o[k];
        end
        exp_q.push_back(it);
    endtask

    // Drive one cycle on one channel, then wait for the sampling edge
    task automatic step(int ch, logic ps, logic sof, logic eof, int len,
                        logic rd, logic emp, logic wr, logic full, logic clr);
        @(negedge clk);
        pkt_start = '0; hdr_sof = '0; hdr_eof = '0; pkt_len = '0;
        rd_req = '0; fifo_empty = '1; wr_req = '0; fifo_full = '0; flag_clr = '0;
        pkt_start[ch] = ps; hdr_sof[ch] = sof; hdr_eof[ch] = eof;
        pkt_len[ch*LW +: LW] = LW'(len);
        rd_req[ch] = rd; fifo_empty[ch] = emp; wr_req[ch] = wr;
        fifo_full[ch] = full; flag_clr[ch] = clr;
        #2;
        if (wr) begin
            n_checks++;
            if (wr_pass[ch] !== (wr & ~full)) begin
                n_fail++;
                $display("FAIL R7 wr_pass ch%0d actual=%b expected=%b", ch, wr_pass[ch], wr & ~full);
            end
        end
        @(posedge clk);
    endtask

    task automatic idle(int ch);
        step(ch, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    endtask

    task automatic rd(int ch, logic emp);
        step(ch, 0, 0, 0, 0, 1, emp, 0, 0, 0);
    endtask

    // Monitor: compare queued expectations against the registered outputs
    initial begin
        exp_t it;
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                n_checks++;
                if (in_frame[it.ch] !== it.f || urun_flag[it.ch] !== it.u ||
                    ovr_flag[it.ch] !== it.o || proto_err[it.ch] !== it.p ||
                    any_urun !== it.au || any_ovr !== it.ao) begin
                    n_fail++;
                    $display("FAIL %s ch%0d actual f%b u%b o%b p%b au%b ao%b expected f%b u%b o%b p%b au%b ao%b",
                             it.tag, it.ch, in_frame[it.ch], urun_flag[it.ch], ovr_flag[it.ch],
                             proto_err[it.ch], any_urun, any_ovr,
                             it.f, it.u, it.o, it.p, it.au, it.ao);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NCH; k++) begin e_u[k] = 0; e_o[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        idle(0); expect_ch("R1", 0, 0, 0, 0, 0); expect_ch("R1", 1, 0, 0, 0, 0);

        // R4: single packet carrying both frame bits, two samples
        step(0, 1, 1, 1, 2, 0, 1, 0, 0, 0); expect_ch("R4", 0, 1, 0, 0, 0);
        rd(0, 0);                           expect_ch("R4", 0, 1, 0, 0, 0);
        rd(0, 0);                           expect_ch("R4", 0, 0, 0, 0, 0);
        rd(0, 1);                           expect_ch("R5", 0, 0, 0, 0, 0);

        // R2, R3: nine-packet frame stays open across every boundary
        for (int p = 0; p < 9; p++) begin
            step(0, 1, p == 0, p == 8, 2, 0, 1, 0, 0, 0); expect_ch("R2", 0, 1, 0, 0, 0);
            rd(0, 0);                                     expect_ch("R2", 0, 1, 0, 0, 0);
            rd(0, 0);                                     expect_ch("R3", 0, p != 8, 0, 0, 0);
        end

        // R5, R6, R9: underrun inside a frame, sticky, cleared
        step(0, 1, 1, 1, 1, 0, 1, 0, 0, 0); expect_ch("R4", 0, 1, 0, 0, 0);
        rd(0, 1);                           expect_ch("R5", 0, 1, 1, 0, 0);
        rd(0, 1);                           expect_ch("R6", 0, 1, 1, 0, 0);
        rd(0, 0);                           expect_ch("R6", 0, 0, 1, 0, 0);
        idle(0);                            expect_ch("R9", 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 1); expect_ch("R9", 0, 0, 0, 0, 0);
        step(0, 1, 1, 0, 1, 0, 1, 0, 0, 0); expect_ch("R2", 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 1, 0, 0, 1); expect_ch("R9", 0, 1, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 1); expect_ch("R9", 0, 1, 0, 0, 0);
        rd(0, 0);                           expect_ch("R3", 0, 1, 0, 0, 0);
        step(0, 1, 0, 1, 0, 0, 1, 0, 0, 0); expect_ch("R4", 0, 0, 0, 0, 0);

        // R7, R10: overrun and channel independence
        step(0, 0, 0, 0, 0, 0, 1, 1, 1, 0); expect_ch("R7", 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 0, 1, 1, 0, 0); expect_ch("R7", 0, 0, 0, 1, 0);
        step(1, 1, 1, 0, 1, 0, 1, 0, 0, 0); expect_ch("R10", 1, 1, 0, 0, 0);
        expect_ch("R10", 0, 0, 0, 1, 0);
        rd(1, 1);                           expect_ch("R10", 1, 1, 1, 0, 0);
        expect_ch("R10", 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 1); expect_ch("R10", 0, 0, 0, 0, 0);
        expect_ch("R10", 1, 1, 1, 0, 0);
        step(1, 0, 0, 0, 0, 0, 1, 0, 0, 1); expect_ch("R10", 1, 1, 0, 0, 0);
        step(1, 1, 0, 1, 0, 0, 1, 0, 0, 0); expect_ch("R4", 1, 0, 0, 0, 0);

        // R8: start-of-frame inside an open frame restarts the count
        step(0, 1, 1, 0, 3, 0, 1, 0, 0, 0); expect_ch("R8", 0, 1, 0, 0, 0);
        rd(0, 0);                           expect_ch("R8", 0, 1, 0, 0, 0);
        step(0, 1, 1, 1, 1, 0, 1, 0, 0, 0); expect_ch("R8", 0, 1, 0, 0, 1);
        rd(0, 0);                           expect_ch("R8", 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 1); expect_ch("R9", 0, 0, 0, 0, 0);

        // R2: stray continuation packet while idle does not open a frame
        step(0, 1, 0, 0, 2, 0, 1, 0, 0, 0); expect_ch("R2", 0, 0, 0, 0, 0);
        rd(0, 0);                           expect_ch("R2", 0, 0, 0, 0, 0);
        rd(0, 1);                           expect_ch("R5", 0, 0, 0, 0, 0);

        idle(0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule